// File: doc/BRIEF.md
# Buck Gate-Drive Sequencing Controller

This block is the clocked control core of a synchronous buck half-bridge. Each clock it reads a three-level PWM command and a three-level mode command, both already reduced to flags. It also reads comparator flags for the low-side gate and the switch node, the sign of the inductor current, and a supply-good flag. From these it drives one enable for the high-side gate and one for the low-side gate.

Dead-time is adaptive. A switch is armed only after the opposite node has been sensed low, and it turns on only after a blanking count has then run out. A PWM input that stays at the mid level shuts both gates down, but only once a holdoff window has passed. When the mode input is low, the low-side switch emulates a diode: it conducts while inductor current is positive and turns off once the current reverses, with a guaranteed minimum on-time. All delays are parameters counted in clock cycles.

Top module: `buck_gate_seq`

## Requirements
- R1: While `vgood` is low, both enables are low. A low `vgood` sampled at an edge forces both off from that edge. Reset leaves both off.
- R2: A floating mode input (`mode_mid`=1) sampled at an edge forces both enables off from that edge, whatever the PWM input is.
- R3: PWM decoding: `pwm_mid`=1 is the mid level, otherwise `pwm_hi` selects high (1) or low (0). Mode decoding: `mode_mid`=1 is floating, otherwise `mode_hi`=1 selects continuous conduction and `mode_hi`=0 selects diode emulation. In continuous conduction, PWM high settles to high side on and low side off, and PWM low settles to the reverse. In both modes, PWM high settles to high side on.
- R4: After the low side has been on, the high side turns on exactly DT_HS edges after the first edge that samples `lg_below` high. It stays off for as long as `lg_below` stays low.
- R5: After the high side has been on, the low side turns on exactly DT_LS edges after the first edge that samples `sw_below` high. It stays off for as long as `sw_below` stays low.
- R6: `pwm_mid` held for HOLD consecutive edges turns both gates off at the HOLD-th edge. A mid level shorter than HOLD edges freezes the gates: they do not change while it lasts.
- R7: Leaving the all-off state (after reset, a supply fault, a floating mode or a PWM shutdown), the gate commanded by a valid PWM level turns on EXIT edges after the first edge that samples that level. No sensing is needed for this.
- R8: In diode emulation, with PWM low, the low side turns on only if `il_pos` is high when its blanking ends. It turns off once `il_pos` is low, and it then stays off until PWM goes high again, even if `il_pos` returns high.
- R9: In diode emulation, once the low side turns on, it stays on for at least MINON cycles, even if `il_pos` falls earlier.
- R10: A PWM level that reverses while a turn-on is still waiting for sensing or blanking cancels that turn-on. Sequencing then restarts toward the new level.
- R11: `hs_en` and `ls_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vgood | input | 1 | Driver supply above lockout threshold |
| pwm_hi | input | 1 | PWM command at high level (valid when pwm_mid is 0) |
| pwm_mid | input | 1 | PWM command at mid (tri-state) level |
| mode_hi | input | 1 | Mode command high: continuous conduction |
| mode_mid | input | 1 | Mode command floating: shutdown |
| lg_below | input | 1 | Low-side gate sensed below 1 V |
| sw_below | input | 1 | Switch node sensed below 1 V |
| il_pos | input | 1 | Inductor current positive (low means zero-crossing seen) |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
Supply and mode faults take effect on the edge that samples them. A sensed node arms a turn-on that lands DT_HS or DT_LS edges later. A shutdown exit lands EXIT edges after the edge that sees the valid level. Tri-state shutdown lands on the HOLD-th consecutive mid edge. Diode-emulation turn-off comes no earlier than MINON cycles after turn-on. The bench drives inputs on the falling edge and runs a behavioural model on the rising edge. It compares both enables on the next falling edge, so each result is checked in the cycle the timing above predicts. The directed checks count the same number of falling edges after each stimulus before they sample.

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int DT_HS = 2,
  parameter int DT_LS = 2,
  parameter int HOLD  = 16,
  parameter int EXIT  = 5,
  parameter int MINON = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vgood,
  input  logic pwm_hi,
  input  logic pwm_mid,
  input  logic mode_hi,
  input  logic mode_mid,
  input  logic lg_below,
  input  logic sw_below,
  input  logic il_pos,
  output logic hs_en,
  output logic ls_en
);

  localparam int M1   = (DT_HS > DT_LS) ? DT_HS : DT_LS;
  localparam int M2   = (EXIT > MINON) ? EXIT : MINON;
  localparam int MAXD = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int MW   = $clog2(HOLD + 1);

  typedef enum logic [2:0] {
    S_OFF, S_HWAIT, S_HBLANK, S_HON, S_LWAIT, S_LBLANK, S_LON, S_PARK
  } st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [MW-1:0] midc;

  wire kill    = !vgood || mode_mid;
  wire tri_off = pwm_mid && (midc == MW'(HOLD - 1));
  wire ccm     = mode_hi;
  wire lo_ok   = ccm || il_pos;
  wire expired = (cnt <= CW'(1));

  assign hs_en = (st == S_HON);
  assign ls_en = (st == S_LON);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (kill || tri_off) begin
      st_n  = S_OFF;
      cnt_n = '0;
    end else if (!pwm_mid) begin
      case (st)
        S_OFF:
          if (pwm_hi) begin st_n = S_HBLANK; cnt_n = CW'(EXIT); end
          else if (lo_ok) begin st_n = S_LBLANK; cnt_n = CW'(EXIT); end
          else st_n = S_PARK;
        S_PARK:
          if (pwm_hi) st_n = S_HWAIT;
          else if (ccm) st_n = S_LWAIT;
        S_HWAIT:
          if (!pwm_hi) st_n = S_LWAIT;
          else if (lg_below) begin st_n = S_HBLANK; cnt_n = CW'(DT_HS); end
        S_HBLANK:
          if (!pwm_hi) st_n = S_LWAIT;
          else if (expired) st_n = S_HON;
          else cnt_n = cnt - CW'(1);
        S_HON:
          if (!pwm_hi) st_n = S_LWAIT;
        S_LWAIT:
          if (pwm_hi) st_n = S_HWAIT;
          else if (sw_below) begin st_n = S_LBLANK; cnt_n = CW'(DT_LS); end
        S_LBLANK:
          if (pwm_hi) st_n = S_HWAIT;
          else if (!expired) cnt_n = cnt - CW'(1);
          else if (lo_ok) begin st_n = S_LON; cnt_n = CW'(MINON - 1); end
          else st_n = S_PARK;
        S_LON:
          if (pwm_hi) st_n = S_HWAIT;
          else if (!ccm && !il_pos && cnt == '0) st_n = S_PARK;
          else if (cnt != '0) cnt_n = cnt - CW'(1);
        default: st_n = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      cnt  <= '0;
      midc <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      if (!pwm_mid) midc <= '0;
      else if (midc != MW'(HOLD - 1)) midc <= midc + MW'(1);
    end
  end

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));
  p_uv_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vgood |=> (!hs_en && !ls_en));
  p_mode_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_mid |=> (!hs_en && !ls_en));
  p_hs_after_ls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(!ls_en));
  p_ls_after_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> $past(!hs_en));
  p_glitch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD > 1 && pwm_mid && midc == '0 && vgood && !mode_mid)
      |=> ($stable(hs_en) && $stable(ls_en)));

endmodule

// File: tb/test_buck_gate_seq.sv
module test_buck_gate_seq;
  localparam int P_DTH = 2, P_DTL = 2, P_HOLD = 16, P_EXIT = 5, P_MIN = 35;
  localparam int Z_OFF = 0, Z_HW = 1, Z_HB = 2, Z_HON = 3,
                 Z_LW = 4, Z_LB = 5, Z_LON = 6, Z_PARK = 7;

  logic clk = 0, rst_n = 0;
  logic vgood = 0, pwm_hi = 0, pwm_mid = 0, mode_hi = 1, mode_mid = 0, il_pos = 1;
  logic stall_lg = 0, stall_sw = 0, hs_q = 0, ls_q = 0;
  logic hs_en, ls_en;
  wire lg_below = !ls_q && !stall_lg;
  wire sw_below = !hs_q && !stall_sw;

  int vectors = 0, errs = 0, cyc = 0;
  int m_st = Z_OFF, m_cnt = 0, m_mid = 0;
  bit m_trig;
  string tag = "R1";

  always #5 clk = ~clk;

  buck_gate_seq #(.DT_HS(P_DTH), .DT_LS(P_DTL), .HOLD(P_HOLD), .EXIT(P_EXIT), .MINON(P_MIN))
  i_buck_gate_seq (
    .clk(clk), .rst_n(rst_n), .vgood(vgood), .pwm_hi(pwm_hi), .pwm_mid(pwm_mid),
    .mode_hi(mode_hi), .mode_mid(mode_mid), .lg_below(lg_below), .sw_below(sw_below),
    .il_pos(il_pos), .hs_en(hs_en), .ls_en(ls_en));

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = Z_OFF; m_cnt = 0; m_mid = 0;
    end else begin
      m_trig = pwm_mid && (m_mid >= P_HOLD - 1);
      if (!vgood || mode_mid || m_trig) begin
        m_st = Z_OFF; m_cnt = 0;
      end else if (!pwm_mid && pwm_hi) begin
        if (m_st == Z_OFF) begin m_st = Z_HB; m_cnt = P_EXIT; end
        else if (m_st == Z_PARK || m_st == Z_LW || m_st == Z_LB || m_st == Z_LON) m_st = Z_HW;
        else if (m_st == Z_HW && lg_below) begin m_st = Z_HB; m_cnt = P_DTH; end
        else if (m_st == Z_HB) begin
          if (m_cnt <= 1) m_st = Z_HON; else m_cnt--;
        end
      end else if (!pwm_mid) begin
        if (m_st == Z_OFF) begin
          if (mode_hi || il_pos) begin m_st = Z_LB; m_cnt = P_EXIT; end else m_st = Z_PARK;
        end else if (m_st == Z_PARK) begin
          if (mode_hi) m_st = Z_LW;
        end else if (m_st == Z_HW || m_st == Z_HB || m_st == Z_HON) m_st = Z_LW;
        else if (m_st == Z_LW && sw_below) begin m_st = Z_LB; m_cnt = P_DTL; end
        else if (m_st == Z_LB) begin
          if (m_cnt > 1) m_cnt--;
          else if (mode_hi || il_pos) begin m_st = Z_LON; m_cnt = P_MIN - 1; end
          else m_st = Z_PARK;
        end else if (m_st == Z_LON) begin
          if (!mode_hi && !il_pos && m_cnt == 0) m_st = Z_PARK;
          else if (m_cnt > 0) m_cnt--;
        end
      end
      m_mid = !pwm_mid ? 0 : (m_mid >= P_HOLD - 1 ? m_mid : m_mid + 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (hs_en !== (m_st == Z_HON) || ls_en !== (m_st == Z_LON)) begin
        errs++;
        $display("FAIL %s: hs/ls got %0b%0b want %0b%0b", tag, hs_en, ls_en,
                 m_st == Z_HON, m_st == Z_LON);
      end
      if (hs_en && ls_en) begin
        errs++;
        $display("FAIL R11: hs/ls got 11 want not both");
      end
    end
    hs_q <= hs_en;
    ls_q <= ls_en;
  end

  task automatic chk(input logic act, input logic exp, input string t);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0b want %0b", t, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL R0: watchdog got hung want finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic seen;
    int run;
    cyc_n(3);
    rst_n = 1;
    chk(hs_en, 0, "R1"); chk(ls_en, 0, "R1");
    // R1: no supply, PWM high
    pwm_hi = 1;
    cyc_n(10);
    chk(hs_en, 0, "R1");
    // R7: supply good, exit delay to high side
    tag = "R7"; vgood = 1;
    cyc_n(P_EXIT); chk(hs_en, 0, "R7");
    cyc_n(1);      chk(hs_en, 1, "R7");
    // R5: switch node sensing stalls low-side turn-on
    tag = "R5"; stall_sw = 1; pwm_hi = 0;
    cyc_n(8); chk(ls_en, 0, "R5"); chk(hs_en, 0, "R5");
    stall_sw = 0;
    cyc_n(P_DTL); chk(ls_en, 0, "R5");
    cyc_n(1);     chk(ls_en, 1, "R5");
    // R4: gate sensing stalls high-side turn-on
    tag = "R4"; stall_lg = 1; pwm_hi = 1;
    cyc_n(8); chk(hs_en, 0, "R4"); chk(ls_en, 0, "R4");
    stall_lg = 0;
    cyc_n(P_DTH); chk(hs_en, 0, "R4");
    cyc_n(1);     chk(hs_en, 1, "R4");
    // R10: reversal during low-side blanking
    tag = "R10"; pwm_hi = 0;
    cyc_n(2); pwm_hi = 1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); seen |= ls_en; end
    chk(seen, 0, "R10"); chk(hs_en, 1, "R10");
    // R6: short mid level leaves gates frozen
    tag = "R6"; pwm_mid = 1; seen = 0;
    for (int i = 0; i < P_HOLD - 1; i++) begin @(negedge clk); seen |= !hs_en; end
    pwm_mid = 0;
    chk(seen, 0, "R6");
    cyc_n(3);
    pwm_mid = 1;
    cyc_n(P_HOLD - 1); chk(hs_en, 1, "R6");
    cyc_n(1);          chk(hs_en, 0, "R6");
    cyc_n(4);
    // R7: exit to low side in continuous conduction (R3)
    tag = "R7"; pwm_mid = 0; pwm_hi = 0;
    cyc_n(P_EXIT); chk(ls_en, 0, "R7");
    cyc_n(1);      chk(ls_en, 1, "R3");
    // R2: floating mode
    tag = "R2"; mode_mid = 1;
    cyc_n(1); chk(ls_en, 0, "R2"); chk(hs_en, 0, "R2");
    cyc_n(5); mode_mid = 0;
    cyc_n(20);
    // R9/R8: diode emulation
    tag = "R9"; mode_hi = 0; il_pos = 1; pwm_hi = 1;
    cyc_n(20); chk(hs_en, 1, "R3");
    pwm_hi = 0;
    for (int i = 0; i < 20 && !ls_en; i++) @(negedge clk);
    chk(ls_en, 1, "R8");
    il_pos = 0;
    seen = 0;
    for (int i = 0; i < P_MIN - 1; i++) begin @(negedge clk); seen |= !ls_en; end
    chk(seen, 0, "R9");
    cyc_n(1); chk(ls_en, 0, "R9");
    tag = "R8"; il_pos = 1;
    cyc_n(10); chk(ls_en, 0, "R8");
    pwm_hi = 1; cyc_n(15);
    il_pos = 0; pwm_hi = 0;
    cyc_n(20); chk(ls_en, 0, "R8");
    pwm_hi = 1; cyc_n(15);
    il_pos = 1; pwm_hi = 0;
    cyc_n(60); chk(ls_en, 1, "R8");
    // mixed random stimulus against the model
    tag = "R3";
    for (int k = 0; k < 300; k++) begin
      run = 1 + int'($urandom_range(0, 30));
      pwm_mid = ($urandom_range(0, 9) == 0);
      pwm_hi = $urandom_range(0, 1);
      mode_hi = $urandom_range(0, 1);
      mode_mid = ($urandom_range(0, 29) == 0);
      vgood = ($urandom_range(0, 39) != 0);
      for (int j = 0; j < run; j++) begin
        il_pos = ($urandom_range(0, 9) != 0);
        stall_lg = ($urandom_range(0, 4) == 0);
        stall_sw = ($urandom_range(0, 4) == 0);
        @(negedge clk);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule